// File: doc/BRIEF.md
# NICAM Audio Source and Mute Controller

This block is the synchronous decision logic of a stereo television sound receiver. It watches the status flags of the digital sound decoder, which are frame lock, an error rate above its limit, data-only content and single-mono (M1) content. It combines them with a host control word and an external test-mute override. From these it drives the source-select code of the reserve-sound switch, the left and right DAC mute lines, an auxiliary mute and a +6 dB gain enable.

A failure of the digital sound is filtered before it takes effect. The status flags are registered, and the filtered failure state only changes after the raw condition has disagreed with it over a programmable number of frame ticks. Recovery uses the same count, so a marginal signal cannot make the source and mutes chatter. Host force bits have priority over the automatic choice of source. The test overrides can lift the automatic DAC mutes, but an explicit host mute still wins over them.

Top module: `nicam_src_mute_ctrl`

## Requirements
- R1: While reset is held, src_sel is 2'b00 (DAC), dac_mute_l, dac_mute_r and aux_mute are 1, and gain6_en is 0.
- R2: In automatic mode with the filtered failure set and cfg_rsv_en high, src_sel becomes 2'b01 (mono input).
- R3: In automatic mode with the filtered failure set and cfg_rsv_en low, src_sel keeps its previous value and both DAC mutes are 1.
- R4: When st_data_only is high in automatic mode, src_sel is 2'b01 (mono) and both DAC mutes are 1.
- R5: cfg_force = 2'b10 selects the mono input (2'b01) and cfg_force = 2'b01 selects the stereo inputs (2'b10), whatever the decoder status.
- R6: cfg_force = 2'b00 or 2'b11 is automatic mode. With healthy status and no host mute, automatic mode gives src_sel 2'b00 with both DAC mutes at 0.
- R7: Loss of frame lock (st_frame_lock low) or st_err_over high sets the filtered failure, and that mutes both DACs.
- R8: When st_m1_only is high and cfg_m1_both is low, only dac_mute_r is 1. When cfg_m1_both is high, neither DAC is muted for that reason. The left DAC is never muted while the right DAC is not.
- R9: tst_unmute_pin high or cfg_unmute high clears both DAC mutes regardless of the automatic conditions. cfg_dac_mute high mutes both DACs regardless of the overrides.
- R10: gain6_en follows cfg_gain6 and aux_mute follows cfg_aux_mute, each one clock later.
- R11: The filtered failure state flips only on a frame_tick, after the raw failure has disagreed with it on N frame ticks with no agreeing cycle between them. N is cfg_fail_frames, and a value of 0 counts as 1. Failure and recovery use the same N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per received frame |
| st_frame_lock | input | 1 | Decoder frame alignment locked |
| st_err_over | input | 1 | Error rate above limit |
| st_data_only | input | 1 | Signal carries data only |
| st_m1_only | input | 1 | Signal carries single mono M1 only |
| cfg_rsv_en | input | 1 | Fall back to mono input on failure |
| cfg_force | input | 2 | 10 force mono, 01 force stereo, 00/11 automatic |
| cfg_m1_both | input | 1 | M1 routed to both DACs |
| cfg_gain6 | input | 1 | +6 dB gain request |
| cfg_dac_mute | input | 1 | Host mute of both DACs |
| cfg_aux_mute | input | 1 | Host mute of auxiliary output |
| cfg_unmute | input | 1 | Host test unmute of DACs |
| cfg_fail_frames | input | CNT_W | Frames a failure or recovery must persist |
| tst_unmute_pin | input | 1 | External test-mute pin override (unmute) |
| src_sel | output | 2 | 00 DAC, 01 mono, 10 stereo |
| dac_mute_l | output | 1 | Left DAC mute |
| dac_mute_r | output | 1 | Right DAC mute |
| aux_mute | output | 1 | Auxiliary output mute |
| gain6_en | output | 1 | +6 dB gain enable |

## Verification
The bench builds the block with CNT_W = 3, so the filter window is programmed at 3 frames and also at 0. That exposes the general threshold, the treatment of 0 as one frame, and a count that restarts when the raw condition briefly agrees again. Because frame ticks are driven one by one, the cycle on which mutes and source change can be pinned to the exact tick. The narrow counter leaves no other behaviour out of reach.

// File: rtl/nicam_src_mute_ctrl.sv
module nicam_src_mute_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             st_frame_lock,
  input  logic             st_err_over,
  input  logic             st_data_only,
  input  logic             st_m1_only,
  input  logic             cfg_rsv_en,
  input  logic [1:0]       cfg_force,
  input  logic             cfg_m1_both,
  input  logic             cfg_gain6,
  input  logic             cfg_dac_mute,
  input  logic             cfg_aux_mute,
  input  logic             cfg_unmute,
  input  logic [CNT_W-1:0] cfg_fail_frames,
  input  logic             tst_unmute_pin,
  output logic [1:0]       src_sel,
  output logic             dac_mute_l,
  output logic             dac_mute_r,
  output logic             aux_mute,
  output logic             gain6_en
);

  localparam logic [1:0] SRC_DAC  = 2'b00;
  localparam logic [1:0] SRC_MONO = 2'b01;
  localparam logic [1:0] SRC_STER = 2'b10;
  localparam int         CW1      = CNT_W + 1;

  logic             s_lock, s_err, s_data, s_m1;
  logic             fail_q;
  logic [CNT_W-1:0] cnt;
  logic             raw_fail, differ, reach;
  logic             auto_mode, unmute_req;
  logic [1:0]       src_nxt;
  logic             auto_l, auto_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_lock <= 1'b0;
      s_err  <= 1'b0;
      s_data <= 1'b0;
      s_m1   <= 1'b0;
    end else begin
      s_lock <= st_frame_lock;
      s_err  <= st_err_over;
      s_data <= st_data_only;
      s_m1   <= st_m1_only;
    end
  end

  assign raw_fail = !s_lock || s_err;
  assign differ   = raw_fail != fail_q;
  assign reach    = (CW1'(cnt) + CW1'(1)) >= CW1'(cfg_fail_frames);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b1;
      cnt    <= '0;
    end else if (!differ) begin
      cnt <= '0;
    end else if (frame_tick) begin
      if (reach) begin
        fail_q <= raw_fail;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign auto_mode  = (cfg_force == 2'b00) || (cfg_force == 2'b11);
  assign unmute_req = tst_unmute_pin || cfg_unmute;

  always_comb begin
    if (cfg_force == 2'b01)      src_nxt = SRC_STER;
    else if (cfg_force == 2'b10) src_nxt = SRC_MONO;
    else if (fail_q)             src_nxt = cfg_rsv_en ? SRC_MONO : src_sel;
    else if (s_data)             src_nxt = SRC_MONO;
    else                         src_nxt = SRC_DAC;
  end

  assign auto_l = fail_q || s_data;
  assign auto_r = auto_l || (s_m1 && !cfg_m1_both);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel    <= SRC_DAC;
      dac_mute_l <= 1'b1;
      dac_mute_r <= 1'b1;
      aux_mute   <= 1'b1;
      gain6_en   <= 1'b0;
    end else begin
      src_sel    <= src_nxt;
      dac_mute_l <= cfg_dac_mute || (auto_l && !unmute_req);
      dac_mute_r <= cfg_dac_mute || (auto_r && !unmute_req);
      aux_mute   <= cfg_aux_mute;
      gain6_en   <= cfg_gain6;
    end
  end

  a_r3_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !cfg_rsv_en && auto_mode) |=> src_sel == $past(src_sel));

  a_r5_force_stereo: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_force == 2'b01) |=> src_sel == SRC_STER);

  a_r8_left_implies_right: assert property (@(posedge clk) disable iff (!rst_n)
    dac_mute_l |-> dac_mute_r);

  a_r9_unmute: assert property (@(posedge clk) disable iff (!rst_n)
    (unmute_req && !cfg_dac_mute) |=> (!dac_mute_l && !dac_mute_r));

  a_r10_gain_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gain6_en == $past(cfg_gain6));

  a_r11_flip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(fail_q));

endmodule

// File: tb/test_nicam_src_mute_ctrl.sv
module test_nicam_src_mute_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic st_frame_lock = 1'b0, st_err_over = 1'b0, st_data_only = 1'b0, st_m1_only = 1'b0;
  logic cfg_rsv_en = 1'b0, cfg_m1_both = 1'b0, cfg_gain6 = 1'b0;
  logic cfg_dac_mute = 1'b0, cfg_aux_mute = 1'b0, cfg_unmute = 1'b0, tst_unmute_pin = 1'b0;
  logic [1:0] cfg_force = 2'b00;
  logic [CNT_W-1:0] cfg_fail_frames = 3'd3;
  logic [1:0] src_sel;
  logic dac_mute_l, dac_mute_r, aux_mute, gain6_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nicam_src_mute_ctrl #(.CNT_W(CNT_W)) i_nicam_src_mute_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .st_frame_lock(st_frame_lock), .st_err_over(st_err_over),
    .st_data_only(st_data_only), .st_m1_only(st_m1_only),
    .cfg_rsv_en(cfg_rsv_en), .cfg_force(cfg_force), .cfg_m1_both(cfg_m1_both),
    .cfg_gain6(cfg_gain6), .cfg_dac_mute(cfg_dac_mute), .cfg_aux_mute(cfg_aux_mute),
    .cfg_unmute(cfg_unmute), .cfg_fail_frames(cfg_fail_frames),
    .tst_unmute_pin(tst_unmute_pin),
    .src_sel(src_sel), .dac_mute_l(dac_mute_l), .dac_mute_r(dac_mute_r),
    .aux_mute(aux_mute), .gain6_en(gain6_en));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input int src, input int ml, input int mr);
    chk({tag, " src_sel"}, src_sel, src);
    chk({tag, " dac_mute_l"}, dac_mute_l, ml);
    chk({tag, " dac_mute_r"}, dac_mute_r, mr);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      @(negedge clk);
    end
    settle();
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 reset src", src_sel, 0);
    chk("R1 reset mute_l", dac_mute_l, 1);
    chk("R1 reset mute_r", dac_mute_r, 1);
    chk("R1 reset aux", aux_mute, 1);
    chk("R1 reset gain", gain6_en, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_healthy();
    st_frame_lock = 1'b1;
    settle();
    tick(3);
    chk_out("R6 healthy auto", 0, 0, 0);
  endtask

  task automatic t_m1();
    st_m1_only = 1'b1;
    settle();
    chk_out("R8 m1 only", 0, 0, 1);
    cfg_m1_both = 1'b1;
    settle();
    chk_out("R8 m1 both", 0, 0, 0);
    st_m1_only = 1'b0;
    cfg_m1_both = 1'b0;
    settle();
  endtask

  task automatic t_data();
    st_data_only = 1'b1;
    settle();
    chk_out("R4 data only", 1, 1, 1);
    st_data_only = 1'b0;
    settle();
    chk_out("R6 back to dac", 0, 0, 0);
  endtask

  task automatic t_force();
    cfg_force = 2'b10;
    settle();
    chk("R5 force mono", src_sel, 1);
    cfg_force = 2'b01;
    st_data_only = 1'b1;
    settle();
    chk("R5 force stereo over data", src_sel, 2);
    st_data_only = 1'b0;
    cfg_force = 2'b11;
    settle();
    chk_out("R6 force 11 auto", 0, 0, 0);
    cfg_force = 2'b00;
    settle();
  endtask

  task automatic t_fail_hold();
    cfg_rsv_en = 1'b0;
    st_data_only = 1'b1;
    settle();
    st_frame_lock = 1'b0;
    settle();
    tick(3);
    st_data_only = 1'b0;
    settle();
    chk_out("R3 fail hold mono", 1, 1, 1);
    cfg_force = 2'b01;
    settle();
    cfg_force = 2'b00;
    settle();
    chk_out("R3 fail hold stereo", 2, 1, 1);
  endtask

  task automatic t_reserve();
    cfg_rsv_en = 1'b1;
    settle();
    chk_out("R2 reserve mono", 1, 1, 1);
    st_frame_lock = 1'b1;
    settle();
    tick(3);
    chk_out("R2 recovered", 0, 0, 0);
    cfg_rsv_en = 1'b0;
  endtask

  task automatic t_debounce();
    st_err_over = 1'b1;
    settle();
    tick(2);
    chk_out("R11 not yet failed", 0, 0, 0);
    tick(1);
    chk_out("R7 err over muted", 0, 1, 1);
    st_err_over = 1'b0;
    settle();
    tick(2);
    st_err_over = 1'b1;
    settle();
    st_err_over = 1'b0;
    settle();
    tick(2);
    chk_out("R11 count restarted", 0, 1, 1);
    tick(1);
    chk_out("R11 recovered after 3", 0, 0, 0);
    cfg_fail_frames = '0;
    st_frame_lock = 1'b0;
    settle();
    chk_out("R11 no tick no change", 0, 0, 0);
    tick(1);
    chk_out("R7 lock loss zero count", 0, 1, 1);
    st_frame_lock = 1'b1;
    settle();
    tick(1);
    chk_out("R11 zero count recover", 0, 0, 0);
    cfg_fail_frames = 3'd3;
  endtask

  task automatic t_unmute();
    st_frame_lock = 1'b0;
    settle();
    tick(3);
    chk_out("R7 failed", 0, 1, 1);
    tst_unmute_pin = 1'b1;
    settle();
    chk_out("R9 pin unmute", 0, 0, 0);
    tst_unmute_pin = 1'b0;
    cfg_unmute = 1'b1;
    settle();
    chk_out("R9 host unmute", 0, 0, 0);
    cfg_dac_mute = 1'b1;
    settle();
    chk_out("R9 host mute wins", 0, 1, 1);
    cfg_dac_mute = 1'b0;
    cfg_unmute = 1'b0;
    st_frame_lock = 1'b1;
    settle();
    tick(3);
    chk_out("R9 restored", 0, 0, 0);
  endtask

  task automatic t_host();
    cfg_gain6 = 1'b1;
    cfg_aux_mute = 1'b1;
    @(negedge clk);
    chk("R10 gain on", gain6_en, 1);
    chk("R10 aux on", aux_mute, 1);
    cfg_gain6 = 1'b0;
    cfg_aux_mute = 1'b0;
    @(negedge clk);
    chk("R10 gain off", gain6_en, 0);
    chk("R10 aux off", aux_mute, 0);
    cfg_dac_mute = 1'b1;
    settle();
    chk_out("R9 host mute healthy", 0, 1, 1);
    cfg_dac_mute = 1'b0;
    settle();
  endtask

  initial begin
    t_reset();
    t_healthy();
    t_m1();
    t_data();
    t_force();
    t_fail_hold();
    t_reserve();
    t_debounce();
    t_unmute();
    t_host();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule